// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps a set of hardware FIFO queues of descriptors. The queues do not own private storage: all of them are singly linked lists threaded through one shared link RAM. Each link-RAM entry holds the index of the descriptor that follows it, and the null index `0x7FFFF` marks the end of a list. For every queue the block keeps a head index, a tail index and an entry count, and it raises one pending flag per queue while that queue holds anything.

Producers push a descriptor byte address to a queue number; consumers pop the oldest descriptor of a queue and get its byte address back one cycle later. Addresses and link-RAM indexes are converted through a table of memory regions. Each region is a block of equal-sized descriptors, described by a base address, a first link-RAM index, a descriptor size and a descriptor count. Software fills the region table through a simple write port before traffic starts, and any queue's occupancy can be read through a combinational count query.

Top module: `qm_desc_queue_mgr`

## Requirements
- R1: After reset every queue is empty: `queue_pend` is all zero and the count query returns 0 for every queue.
- R2: A region table write takes effect only if it disables the region or if its base has bits [3:0] zero, its size code (log2 of descriptor bytes) is at least 5 and its count code (log2 of descriptor count) lies between 5 and 19; any other write leaves the entry unchanged. A disabled region matches no address.
- R3: A pushed address A that falls inside enabled region r is stored as index start + (A - base) >> size code, and a pop of that entry returns base + ((index - start) << size code), which gives back A for descriptor-aligned addresses.
- R4: Each queue is first-in first-out, and queues are independent: pops of one queue never return descriptors pushed to another.
- R5: The count query (`cnt_queue` selects, `cnt_value` answers in the same cycle) returns the number of descriptors the selected queue holds, and `queue_pend[q]` is 1 exactly when queue q holds at least one descriptor.
- R6: Popping an empty queue returns a response with address 0 and changes no count, head or tail.
- R7: A push whose address lies in no enabled region, or whose translated index is not below the link-RAM depth, is dropped: the queue count is unchanged and `push_err` is 1 during the cycle after the push.
- R8: At most one operation completes per cycle. `push_ready` is always 1; when `push_valid` and `pop_valid` are both high the push is taken and `pop_ready` is 0, and the pop is taken in a later cycle.
- R9: `pop_rsp_valid` is high for exactly the one cycle after a pop is accepted, with `pop_rsp_addr` holding its address.
- R10: When the last descriptor of a queue is popped the queue returns to its empty state, and the next push to it becomes both head and tail, so a drained queue refills correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region table write strobe |
| cfg_region | input | $clog2(NUM_REGIONS) | Region table entry to write |
| cfg_enable | input | 1 | Region enable for the write |
| cfg_base | input | 32 | Region base byte address |
| cfg_start | input | 19 | First link-RAM index of the region |
| cfg_size_log2 | input | 4 | log2 of descriptor size in bytes |
| cfg_count_log2 | input | 5 | log2 of descriptor count |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Push accepted |
| push_queue | input | $clog2(NUM_QUEUES) | Target queue of the push |
| push_addr | input | 32 | Descriptor byte address to push |
| push_err | output | 1 | Previous cycle's push was dropped |
| pop_valid | input | 1 | Pop request |
| pop_ready | output | 1 | Pop accepted |
| pop_queue | input | $clog2(NUM_QUEUES) | Queue to pop |
| pop_rsp_valid | output | 1 | Pop response present |
| pop_rsp_addr | output | 32 | Popped address, 0 if the queue was empty |
| cnt_queue | input | $clog2(NUM_QUEUES) | Queue selected for the count query |
| cnt_value | output | $clog2(LINK_DEPTH+1) | Entry count of the selected queue |
| queue_pend | output | NUM_QUEUES | Per-queue non-empty flags |

## Verification
The hardest state to reach from the ports is a push that lands in an enabled region but translates to an index at or beyond the link-RAM depth, since it needs a region whose index range straddles the end of the RAM; the bench configures such a region and pushes one descriptor below the boundary and one above it. A second awkward case is a push and a pop presented in the same cycle, which the bench creates by raising both requests together and checking the ready signals before and after the push is taken. Draining a queue to empty and refilling it exercises the null tail link, and popping a never-used queue covers the empty response.

// File: rtl/qm_pkg.sv
package qm_pkg;

    localparam int QM_ADDR_W   = 32;
    localparam int QM_IDX_W    = 19;
    localparam int QM_SZ_W     = 4;
    localparam int QM_CNT_W    = 5;

    typedef logic [QM_ADDR_W-1:0] qm_addr_t;
    typedef logic [QM_IDX_W-1:0]  qm_idx_t;

    localparam qm_idx_t QM_NULL_IDX = 19'h7FFFF;

    typedef struct packed {
        logic                en;
        qm_addr_t            base;
        qm_idx_t             start;
        logic [QM_SZ_W-1:0]  size_lg;
        logic [QM_CNT_W-1:0] cnt_lg;
    } qm_region_t;

    // An entry may always be disabled; an enabled one must obey the layout rules.
    function automatic logic qm_region_legal(qm_region_t r);
        return !r.en ||
               ((r.base[3:0] == 4'd0) &&
                (r.size_lg >= 4'd5) &&
                (r.cnt_lg >= 5'd5) && (r.cnt_lg <= 5'd19));
    endfunction

    function automatic logic [5:0] qm_span_lg(qm_region_t r);
        return {2'b00, r.size_lg} + {1'b0, r.cnt_lg};
    endfunction

endpackage

// File: rtl/qm_region_map.sv
module qm_region_map
    import qm_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    parameter  int LINK_DEPTH  = 1024,
    localparam int RGN_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [RGN_W-1:0] cfg_sel,
    input  qm_region_t       cfg_data,
    input  qm_addr_t         lk_addr,
    output logic             lk_hit,
    output qm_idx_t          lk_idx,
    input  qm_idx_t          rv_idx,
    output logic             rv_hit,
    output qm_addr_t         rv_addr
);

    localparam logic [QM_IDX_W:0] DEPTH_V = (QM_IDX_W+1)'(LINK_DEPTH);

    qm_region_t tbl [NUM_REGIONS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                tbl[i] <= '0;
            end
        end else if (cfg_we && qm_region_legal(cfg_data)) begin
            tbl[cfg_sel] <= cfg_data;
        end
    end

    logic [NUM_REGIONS-1:0]                fwd_hit;
    logic [NUM_REGIONS-1:0][QM_IDX_W-1:0]  fwd_idx;
    logic [NUM_REGIONS-1:0]                rev_hit;
    logic [NUM_REGIONS-1:0][QM_ADDR_W-1:0] rev_addr;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        qm_addr_t          off;
        qm_idx_t           loc;
        logic [QM_IDX_W:0] sum;
        qm_idx_t           dlt;

        // address to index
        assign off = lk_addr - tbl[g].base;
        assign loc = QM_IDX_W'(off >> tbl[g].size_lg);
        assign sum = {1'b0, tbl[g].start} + {1'b0, loc};
        assign fwd_idx[g] = sum[QM_IDX_W-1:0];
        assign fwd_hit[g] = tbl[g].en && (lk_addr >= tbl[g].base) &&
                            ((off >> qm_span_lg(tbl[g])) == '0) &&
                            (sum < DEPTH_V);

        // index to address
        assign dlt = rv_idx - tbl[g].start;
        assign rev_hit[g]  = tbl[g].en && (rv_idx >= tbl[g].start) &&
                             ((dlt >> tbl[g].cnt_lg) == '0);
        assign rev_addr[g] = tbl[g].base + (QM_ADDR_W'(dlt) << tbl[g].size_lg);

        a_r2_entry_legal: assert property (@(posedge clk) disable iff (rst)
            tbl[g].en |-> qm_region_legal(tbl[g]))
            else $error("R2: enabled region entry breaks layout rules");
    end

    // lowest numbered matching region wins
    always_comb begin
        lk_hit  = 1'b0;
        lk_idx  = QM_NULL_IDX;
        rv_hit  = 1'b0;
        rv_addr = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (fwd_hit[i]) begin
                lk_hit = 1'b1;
                lk_idx = fwd_idx[i];
            end
            if (rev_hit[i]) begin
                rv_hit  = 1'b1;
                rv_addr = rev_addr[i];
            end
        end
    end

endmodule

// File: rtl/qm_link_ram.sv
module qm_link_ram
    import qm_pkg::*;
#(
    parameter  int LINK_DEPTH = 1024,
    localparam int LAW        = $clog2(LINK_DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [LAW-1:0] rd_addr,
    output qm_idx_t        rd_data,
    input  logic           wa_en,
    input  logic [LAW-1:0] wa_addr,
    input  qm_idx_t        wa_data,
    input  logic           wb_en,
    input  logic [LAW-1:0] wb_addr,
    input  qm_idx_t        wb_data
);

    qm_idx_t mem [LINK_DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (wa_en) begin
            mem[wa_addr] <= wa_data;
        end
        if (wb_en) begin
            mem[wb_addr] <= wb_data;
        end
    end

    // R3: the new entry's null link and the old tail's forward link never collide
    a_r3_distinct_writes: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |-> (wa_addr != wb_addr))
        else $error("R3: both link writes target one entry");

endmodule

// File: rtl/qm_desc_queue_mgr.sv
module qm_desc_queue_mgr
    import qm_pkg::*;
#(
    parameter  int NUM_QUEUES  = 64,
    parameter  int NUM_REGIONS = 8,
    parameter  int LINK_DEPTH  = 1024,
    localparam int QW          = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
    localparam int RGN_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int CNT_W       = $clog2(LINK_DEPTH + 1),
    localparam int LAW         = $clog2(LINK_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [RGN_W-1:0]      cfg_region,
    input  logic                  cfg_enable,
    input  logic [QM_ADDR_W-1:0]  cfg_base,
    input  logic [QM_IDX_W-1:0]   cfg_start,
    input  logic [QM_SZ_W-1:0]    cfg_size_log2,
    input  logic [QM_CNT_W-1:0]   cfg_count_log2,
    input  logic                  push_valid,
    output logic                  push_ready,
    input  logic [QW-1:0]         push_queue,
    input  logic [QM_ADDR_W-1:0]  push_addr,
    output logic                  push_err,
    input  logic                  pop_valid,
    output logic                  pop_ready,
    input  logic [QW-1:0]         pop_queue,
    output logic                  pop_rsp_valid,
    output logic [QM_ADDR_W-1:0]  pop_rsp_addr,
    input  logic [QW-1:0]         cnt_queue,
    output logic [CNT_W-1:0]      cnt_value,
    output logic [NUM_QUEUES-1:0] queue_pend
);

    qm_idx_t          head_q [NUM_QUEUES];
    qm_idx_t          tail_q [NUM_QUEUES];
    logic [CNT_W-1:0] cnt_q  [NUM_QUEUES];

    qm_region_t cfg_word;
    logic       push_fire, pop_fire;
    logic       map_hit, rev_hit;
    qm_idx_t    map_idx;
    qm_addr_t   rev_addr;
    qm_idx_t    pop_head, link_next;
    logic       push_nonempty, pop_nonempty;

    assign cfg_word = '{en: cfg_enable, base: cfg_base, start: cfg_start,
                        size_lg: cfg_size_log2, cnt_lg: cfg_count_log2};

    // push always wins the single operation slot
    assign push_ready    = 1'b1;
    assign pop_ready     = !push_valid;
    assign push_fire     = push_valid;
    assign pop_fire      = pop_valid && !push_valid;
    assign pop_head      = head_q[pop_queue];
    assign push_nonempty = (cnt_q[push_queue] != '0);
    assign pop_nonempty  = (cnt_q[pop_queue] != '0);

    qm_region_map #(
        .NUM_REGIONS (NUM_REGIONS),
        .LINK_DEPTH  (LINK_DEPTH)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_region),
        .cfg_data (cfg_word),
        .lk_addr  (push_addr),
        .lk_hit   (map_hit),
        .lk_idx   (map_idx),
        .rv_idx   (pop_head),
        .rv_hit   (rev_hit),
        .rv_addr  (rev_addr)
    );

    qm_link_ram #(
        .LINK_DEPTH (LINK_DEPTH)
    ) u_link (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (pop_head[LAW-1:0]),
        .rd_data (link_next),
        .wa_en   (push_fire && map_hit),
        .wa_addr (map_idx[LAW-1:0]),
        .wa_data (QM_NULL_IDX),
        .wb_en   (push_fire && map_hit && push_nonempty),
        .wb_addr (tail_q[push_queue][LAW-1:0]),
        .wb_data (map_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_QUEUES; i++) begin
                head_q[i] <= QM_NULL_IDX;
                tail_q[i] <= QM_NULL_IDX;
                cnt_q[i]  <= '0;
            end
            push_err      <= 1'b0;
            pop_rsp_valid <= 1'b0;
            pop_rsp_addr  <= '0;
        end else begin
            push_err      <= push_fire && !map_hit;
            pop_rsp_valid <= pop_fire;
            pop_rsp_addr  <= (pop_fire && pop_nonempty && rev_hit) ? rev_addr : '0;
            if (push_fire && map_hit) begin
                if (!push_nonempty) begin
                    head_q[push_queue] <= map_idx;
                end
                tail_q[push_queue] <= map_idx;
                cnt_q[push_queue]  <= cnt_q[push_queue] + CNT_W'(1);
            end else if (pop_fire && pop_nonempty) begin
                head_q[pop_queue] <= link_next;
                cnt_q[pop_queue]  <= cnt_q[pop_queue] - CNT_W'(1);
                if (cnt_q[pop_queue] == CNT_W'(1)) begin
                    tail_q[pop_queue] <= QM_NULL_IDX;
                end
            end
        end
    end

    assign cnt_value = cnt_q[cnt_queue];

    always_comb begin
        for (int i = 0; i < NUM_QUEUES; i++) begin
            queue_pend[i] = (cnt_q[i] != '0);
        end
    end

    a_r5_push_counts_up: assert property (@(posedge clk) disable iff (rst)
        (push_fire && map_hit) |=>
            (cnt_q[$past(push_queue)] == $past(cnt_q[push_queue]) + CNT_W'(1)))
        else $error("R5: accepted push did not raise the count");

    a_r7_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (push_fire && !map_hit) |=>
            (push_err && (cnt_q[$past(push_queue)] == $past(cnt_q[push_queue]))))
        else $error("R7: dropped push changed state or gave no error");

    a_r6_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
        (pop_fire && !pop_nonempty) |=> (pop_rsp_valid && (pop_rsp_addr == '0)))
        else $error("R6: empty pop did not return address zero");

    a_r10_last_pop_nulls_head: assert property (@(posedge clk) disable iff (rst)
        (pop_fire && (cnt_q[pop_queue] == CNT_W'(1))) |=>
            (head_q[$past(pop_queue)] == QM_NULL_IDX))
        else $error("R10: head not null after the last pop");

    a_r8_single_op: assert property (@(posedge clk) disable iff (rst)
        (push_valid && pop_valid) |=> !pop_rsp_valid)
        else $error("R8: pop completed alongside a push");

endmodule

// File: tb/qm_desc_queue_mgr_tb_top.sv
module qm_desc_queue_mgr_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NQ         = 64;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_region = '0;
    logic        cfg_enable = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [18:0] cfg_start = '0;
    logic [3:0]  cfg_size_log2 = '0;
    logic [4:0]  cfg_count_log2 = '0;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [5:0]  push_queue = '0;
    logic [31:0] push_addr = '0;
    logic        push_err;
    logic        pop_valid = 1'b0;
    logic        pop_ready;
    logic [5:0]  pop_queue = '0;
    logic        pop_rsp_valid;
    logic [31:0] pop_rsp_addr;
    logic [5:0]  cnt_queue = '0;
    logic [10:0] cnt_value;
    logic [63:0] queue_pend;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [31:0] model_q [NQ][$];
    logic [31:0] exp_rsp [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    qm_desc_queue_mgr dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_enable(cfg_enable),
        .cfg_base(cfg_base), .cfg_start(cfg_start),
        .cfg_size_log2(cfg_size_log2), .cfg_count_log2(cfg_count_log2),
        .push_valid(push_valid), .push_ready(push_ready), .push_queue(push_queue),
        .push_addr(push_addr), .push_err(push_err),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_queue(pop_queue),
        .pop_rsp_valid(pop_rsp_valid), .pop_rsp_addr(pop_rsp_addr),
        .cnt_queue(cnt_queue), .cnt_value(cnt_value), .queue_pend(queue_pend)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_region(input int r, input bit en, input logic [31:0] base,
                              input logic [18:0] start, input int sz, input int cn);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = 3'(r); cfg_enable = en; cfg_base = base;
        cfg_start = start; cfg_size_log2 = 4'(sz); cfg_count_log2 = 5'(cn);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_push(input int q, input logic [31:0] a, input bit exp_err, input string tag);
        @(negedge clk);
        push_valid = 1'b1; push_queue = 6'(q); push_addr = a;
        @(negedge clk);
        push_valid = 1'b0;
        chk(push_err == exp_err, tag, 32'(push_err), 32'(exp_err));
        if (!exp_err) model_q[q].push_back(a);
    endtask

    task automatic do_pop(input int q);
        @(negedge clk);
        pop_valid = 1'b1; pop_queue = 6'(q);
        if (model_q[q].size() == 0) exp_rsp.push_back(32'h0);
        else exp_rsp.push_back(model_q[q].pop_front());
        @(negedge clk);
        pop_valid = 1'b0;
        chk(pop_rsp_valid == 1'b1, "R9 response one cycle after pop", 32'(pop_rsp_valid), 32'd1);
    endtask

    task automatic check_count(input int q, input string tag);
        @(negedge clk);
        cnt_queue = 6'(q);
        #1;
        chk(cnt_value == 11'(model_q[q].size()), tag, 32'(cnt_value), 32'(model_q[q].size()));
        chk(queue_pend[q] == (model_q[q].size() != 0), {tag, " pend"},
            32'(queue_pend[q]), 32'(model_q[q].size() != 0));
    endtask

    // monitor: compares each response with the scoreboard head
    always @(negedge clk) begin : mon
        logic [31:0] e;
        if (!rst && pop_rsp_valid) begin
            if (exp_rsp.size() == 0) begin
                chk(1'b0, "R9 unexpected response", pop_rsp_addr, 32'h0);
            end else begin
                e = exp_rsp.pop_front();
                chk(pop_rsp_addr == e, "R4 R3 R6 popped address", pop_rsp_addr, e);
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired act=0x0 exp=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk(queue_pend == '0, "R1 pend after reset", 32'(queue_pend[31:0]), 32'h0);
        check_count(0, "R1 count q0");
        check_count(63, "R1 count q63");

        // region table: legal, illegal and boundary-straddling entries
        set_region(0, 1'b1, 32'h1000_0000, 19'd0,    5, 5);
        set_region(1, 1'b1, 32'h2000_0000, 19'd100,  6, 6);
        set_region(2, 1'b1, 32'h3000_0008, 19'd200,  5, 5);  // misaligned base
        set_region(3, 1'b1, 32'h4000_0000, 19'd300,  4, 5);  // size code too small
        set_region(4, 1'b1, 32'h5000_0000, 19'd1000, 5, 6);  // crosses link RAM end

        do_push(9, 32'h3000_0040, 1'b1, "R2 misaligned-base region ignored");
        do_push(9, 32'h4000_0000, 1'b1, "R2 small-size region ignored");
        check_count(9, "R7 count after dropped pushes");

        // R6 empty pop
        do_pop(5);
        check_count(5, "R6 count after empty pop");

        // R3 R4 R5 one queue, several regions
        do_push(1, 32'h1000_0000, 1'b0, "R3 push region0 first");
        do_push(1, 32'h2000_0040, 1'b0, "R3 push region1");
        do_push(1, 32'h1000_03E0, 1'b0, "R3 push region0 last");
        do_push(1, 32'h5000_0140, 1'b0, "R3 push below link end");
        check_count(1, "R5 count four");
        do_pop(1);
        do_pop(1);
        check_count(1, "R5 count after two pops");
        do_pop(1);
        do_pop(1);
        check_count(1, "R10 count drained");

        // R7 outside every region / beyond link RAM
        do_push(2, 32'h0000_0000, 1'b1, "R7 address in no region");
        do_push(2, 32'h1000_0400, 1'b1, "R7 just past region0");
        do_push(2, 32'h5000_03C0, 1'b1, "R7 index beyond link RAM");
        check_count(2, "R7 count unchanged");

        // R4 independent queues, interleaved
        do_push(2, 32'h1000_0020, 1'b0, "R4 push q2 a");
        do_push(3, 32'h2000_0080, 1'b0, "R4 push q3 c");
        do_push(2, 32'h1000_0040, 1'b0, "R4 push q2 b");
        do_pop(3);
        do_pop(2);
        check_count(2, "R5 q2 one left");
        check_count(3, "R5 q3 empty");
        do_pop(2);

        // R10 drain then refill
        do_push(4, 32'h1000_0060, 1'b0, "R10 push");
        do_pop(4);
        do_push(4, 32'h2000_0100, 1'b0, "R10 refill");
        do_push(4, 32'h1000_0080, 1'b0, "R10 refill second");
        check_count(4, "R10 refilled count");
        do_pop(4);
        do_pop(4);

        // R8 push and pop together
        do_push(6, 32'h1000_00A0, 1'b0, "R8 seed q6");
        @(negedge clk);
        push_valid = 1'b1; push_queue = 6'd7; push_addr = 32'h1000_00C0;
        pop_valid  = 1'b1; pop_queue  = 6'd6;
        #1;
        chk(push_ready == 1'b1, "R8 push ready", 32'(push_ready), 32'd1);
        chk(pop_ready == 1'b0, "R8 pop held", 32'(pop_ready), 32'd0);
        @(negedge clk);
        push_valid = 1'b0;
        model_q[7].push_back(32'h1000_00C0);
        exp_rsp.push_back(model_q[6].pop_front());
        #1;
        chk(pop_ready == 1'b1, "R8 pop ready after push", 32'(pop_ready), 32'd1);
        chk(pop_rsp_valid == 1'b0, "R8 no pop in push cycle", 32'(pop_rsp_valid), 32'd0);
        @(negedge clk);
        pop_valid = 1'b0;
        check_count(7, "R8 pushed item counted");
        check_count(6, "R8 pop drained q6");
        do_pop(7);

        // R2 disabling a region
        set_region(1, 1'b0, 32'h2000_0000, 19'd100, 6, 6);
        do_push(8, 32'h2000_0000, 1'b1, "R2 disabled region misses");
        check_count(8, "R2 count after disabled push");

        repeat (3) @(negedge clk);
        chk(exp_rsp.size() == 0, "R9 all responses seen", 32'(exp_rsp.size()), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule